// File: doc/BRIEF.md
# Data Address Translation Check with Fault Capture

This block sits on the load/store side of a processor's memory pipeline. It takes a virtual address and the request attributes, picks the privilege mode that governs the access, and classifies the request. A request is either a physical access, an access to the kernel-only direct-mapped window, or a page-table access whose entry comes from an external lookup array. For page-table accesses it checks the read or write enable for the chosen mode and the fault-on-read / fault-on-write bits. It returns a registered result code and a physical address. The lookup array itself lives outside this block. The block presents it a page number and address-space number and receives a hit flag and the entry fields back in the same cycle.

When a request faults, the block records the faulting address, a packed status word and a formatted page-table address in three holding registers, then locks them. Later faults leave these registers unchanged until software reads the fault address register, which is signalled by a one-cycle pulse on `rd_va_i`. Six wrapping event counters tally hits, misses and violations separately for reads and for writes.

Top module: `dtx_unit`

## Requirements
- R1: After reset `vld_o`, `lock_o`, `fault_va_o`, `mm_stat_o`, `va_form_o` and every counter are zero.
- R2: Mode encoding is 0 kernel, 1 executive, 2 supervisor, 3 user, and the permission masks are indexed by mode (bit m enables mode m). When `priv_pc_i` is set, the effective mode is `alt_mode_i` if `alt_i` is set and kernel otherwise. When `priv_pc_i` is clear, the effective mode is `cur_mode_i`.
- R3: With `phys_i` set, `pa_o` = `va_i[43:0]`. The result is 5 (machine check) if any of `va_i[63:44]` is set and 0 otherwise, and no fault status is captured.
- R4: A virtual address whose bits 63:47 are not all equal gives result 2, with causes write (when writing), access violation and bad address.
- R5: When `va_i[47:41]` = 7'h7E, the access uses the direct window. If `cur_mode_i` is kernel, the result is 0 and `pa_o` = {4 copies of `va_i[40]`, `va_i[39:0]`}. Otherwise the result is 1 with causes write (when writing) and access violation. The effective mode plays no part in this decision.
- R6: A lookup miss gives result 4 when `pte_acc_i` is set and 3 otherwise, with causes write (when writing) and miss.
- R7: On a write hit, a clear write enable for the effective mode gives result 2 with causes write, access violation, and fault-on-write if that bit is set. Otherwise a set fault-on-write bit gives result 2 with causes write and fault-on-write.
- R8: On a read hit, a clear read enable for the effective mode gives result 1 with cause access violation, plus fault-on-read if that bit is set. Otherwise a set fault-on-read bit gives result 2 with cause fault-on-read.
- R9: A permitted hit gives result 0 with `pa_o` = {`lk_ppn_i`, `va_i[12:0]`}. `lk_vpn_o` = `va_i[47:13]` and `lk_asn_o` = `asn_i` in the same cycle.
- R10: On capture, `fault_va_o` = the address, `mm_stat_o` = `opcode_i`<<11 | `dst_reg_i`<<6 | causes, and `va_form_o` = `ptbr_i` | (`va_i[47:13]`<<3). Cause bit positions are: write 0, access violation 1, fault-on-read 2, fault-on-write 3, miss 4, bad address 5.
- R11: Results 1 to 4 capture status only while `lock_o` is clear, and a capture sets `lock_o`. When `rd_va_i` is pulsed without a capture, it clears `lock_o`. A capture in the same cycle as the read leaves `lock_o` set.
- R12: `cnt_o` index 0..5 counts read hits, read misses, read violations, write hits, write misses and write violations. Results 0 and 5 count as hits, 3 and 4 as misses, and 1 and 2 as violations.
- R13: Result codes are 0 none, 1 access violation, 2 fault, 3 miss, 4 entry-access miss, 5 machine check. `vld_o`, `res_o` and `pa_o` appear on the clock edge after `req_i`, and `vld_o` lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request |
| va_i | input | 64 | Virtual address |
| wr_i | input | 1 | Store when set |
| alt_i | input | 1 | Use alternate mode in privileged code |
| pte_acc_i | input | 1 | Request fetches a page-table entry |
| phys_i | input | 1 | Address is already physical |
| priv_pc_i | input | 1 | PC is in privileged code |
| cur_mode_i | input | 2 | Current mode |
| alt_mode_i | input | 2 | Alternate mode |
| asn_i | input | 8 | Address-space number |
| opcode_i | input | 6 | Instruction opcode |
| dst_reg_i | input | 5 | Destination register number |
| ptbr_i | input | 64 | Page-table base for formatted address |
| rd_va_i | input | 1 | Fault address register is being read |
| lk_vpn_o | output | 35 | Page number to lookup array |
| lk_asn_o | output | 8 | Address-space number to lookup array |
| lk_hit_i | input | 1 | Lookup hit |
| lk_ppn_i | input | 31 | Physical page number of hit entry |
| lk_rd_en_i | input | 4 | Read enable per mode |
| lk_wr_en_i | input | 4 | Write enable per mode |
| lk_fonr_i | input | 1 | Fault-on-read bit |
| lk_fonw_i | input | 1 | Fault-on-write bit |
| vld_o | output | 1 | Result valid |
| res_o | output | 3 | Result code |
| pa_o | output | 44 | Physical address |
| fault_va_o | output | 64 | Captured fault address |
| mm_stat_o | output | 17 | Captured status word |
| va_form_o | output | 64 | Captured formatted address |
| lock_o | output | 1 | Fault registers locked |
| cnt_o | output | 6x16 | Event counters |

## Verification
Requests are run through each path: physical addresses with and without high bits, the direct window with bit 40 set and clear and under a non-kernel current mode, misses with and without the entry-access flag, and hits crossing both enable states with both fault bits. These separate the priority order of the checks and the cause sets that go with them. Hits under privileged code with and without the alternate flag, with masks chosen so only one mode passes, separate the three sources of the effective mode. Faults arriving while the registers are locked, reads with and without a coincident fault, and back-to-back requests expose the capture, lock and release order.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_ACV   = 3'd1,
    RES_FLT   = 3'd2,
    RES_MISS  = 3'd3,
    RES_PMISS = 3'd4,
    RES_MCHK  = 3'd5
  } dtx_res_e;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_EXEC = 2'd1,
    MODE_SUPV = 2'd2,
    MODE_USER = 2'd3
  } dtx_mode_e;

  localparam int CB_WR    = 0;
  localparam int CB_ACV   = 1;
  localparam int CB_FONR  = 2;
  localparam int CB_FONW  = 3;
  localparam int CB_MISS  = 4;
  localparam int CB_BADVA = 5;
  localparam int CB_W     = 6;

  localparam int N_CNT = 6;
  localparam int CI_RD_HIT  = 0;
  localparam int CI_RD_MISS = 1;
  localparam int CI_RD_VIOL = 2;
  localparam int CI_WR_HIT  = 3;
  localparam int CI_WR_MISS = 4;
  localparam int CI_WR_VIOL = 5;

  function automatic logic res_is_fault(dtx_res_e r);
    return (r == RES_ACV) || (r == RES_FLT) || (r == RES_MISS) || (r == RES_PMISS);
  endfunction
endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel
  import dtx_pkg::*;
(
  input  logic      priv_pc_i,
  input  logic      alt_i,
  input  dtx_mode_e cur_mode_i,
  input  dtx_mode_e alt_mode_i,
  output dtx_mode_e eff_mode_o
);
  always_comb begin
    if (!priv_pc_i)  eff_mode_o = cur_mode_i;
    else if (alt_i)  eff_mode_o = alt_mode_i;
    else             eff_mode_o = MODE_KERN;
  end
endmodule

// File: rtl/dtx_classify.sv
module dtx_classify
  import dtx_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int VA_IMPL  = 48,
  parameter int PG_BITS  = 13,
  parameter int PPN_W    = 31,
  parameter int SP_BIT   = 40,
  parameter logic [6:0] SP_TAG = 7'h7E,
  localparam int PA_W    = PPN_W + PG_BITS
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             wr_i,
  input  logic             pte_acc_i,
  input  logic             phys_i,
  input  dtx_mode_e        cur_mode_i,
  input  dtx_mode_e        eff_mode_i,
  input  logic             hit_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [3:0]       rd_en_i,
  input  logic [3:0]       wr_en_i,
  input  logic             fonr_i,
  input  logic             fonw_i,
  output dtx_res_e         res_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [CB_W-1:0]  cause_o
);
  localparam int EXT_W = VA_W - VA_IMPL + 1;

  logic [EXT_W-1:0] va_ext;
  logic             va_ok;
  logic             in_window;
  logic             mode_rd_ok;
  logic             mode_wr_ok;

  assign va_ext     = va_i[VA_W-1:VA_IMPL-1];
  assign va_ok      = (&va_ext) | ~(|va_ext);
  assign in_window  = va_i[VA_IMPL-1:VA_IMPL-7] == SP_TAG;
  assign mode_rd_ok = rd_en_i[eff_mode_i];
  assign mode_wr_ok = wr_en_i[eff_mode_i];

  always_comb begin
    res_o   = RES_OK;
    pa_o    = '0;
    cause_o = '0;
    if (phys_i) begin
      pa_o = va_i[PA_W-1:0];
      if (|va_i[VA_W-1:PA_W]) res_o = RES_MCHK;
    end else if (!va_ok) begin
      res_o = RES_FLT;
      cause_o[CB_WR]    = wr_i;
      cause_o[CB_ACV]   = 1'b1;
      cause_o[CB_BADVA] = 1'b1;
    end else if (in_window) begin
      if (cur_mode_i != MODE_KERN) begin
        res_o = RES_ACV;
        cause_o[CB_WR]  = wr_i;
        cause_o[CB_ACV] = 1'b1;
      end else begin
        pa_o = {{(PA_W-SP_BIT){va_i[SP_BIT]}}, va_i[SP_BIT-1:0]};
      end
    end else if (!hit_i) begin
      res_o = pte_acc_i ? RES_PMISS : RES_MISS;
      cause_o[CB_WR]   = wr_i;
      cause_o[CB_MISS] = 1'b1;
    end else begin
      pa_o = {ppn_i, va_i[PG_BITS-1:0]};
      if (wr_i) begin
        // enable check outranks the fault-on bit
        if (!mode_wr_ok) begin
          res_o = RES_FLT;
          cause_o[CB_WR]   = 1'b1;
          cause_o[CB_ACV]  = 1'b1;
          cause_o[CB_FONW] = fonw_i;
        end else if (fonw_i) begin
          res_o = RES_FLT;
          cause_o[CB_WR]   = 1'b1;
          cause_o[CB_FONW] = 1'b1;
        end
      end else begin
        if (!mode_rd_ok) begin
          res_o = RES_ACV;
          cause_o[CB_ACV]  = 1'b1;
          cause_o[CB_FONR] = fonr_i;
        end else if (fonr_i) begin
          res_o = RES_FLT;
          cause_o[CB_FONR] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dtx_fault_regs.sv
module dtx_fault_regs
  import dtx_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PG_BITS = 13,
  localparam int VPN_W  = VA_IMPL - PG_BITS,
  localparam int STAT_W = 6 + 5 + CB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic              rd_va_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [CB_W-1:0]   cause_i,
  input  logic [5:0]        opcode_i,
  input  logic [4:0]        dst_reg_i,
  input  logic [VA_W-1:0]   ptbr_i,
  output logic [VA_W-1:0]   fault_va_o,
  output logic [STAT_W-1:0] mm_stat_o,
  output logic [VA_W-1:0]   va_form_o,
  output logic              lock_o
);
  logic             cap;
  logic [VPN_W-1:0] vpn;

  assign cap = fault_i & ~lock_o;
  assign vpn = va_i[VA_IMPL-1:PG_BITS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_va_o <= '0;
      mm_stat_o  <= '0;
      va_form_o  <= '0;
      lock_o     <= 1'b0;
    end else begin
      if (cap) begin
        fault_va_o <= va_i;
        mm_stat_o  <= {opcode_i, dst_reg_i, cause_i};
        va_form_o  <= ptbr_i | (VA_W'(vpn) << 3);
      end
      if (cap)          lock_o <= 1'b1;
      else if (rd_va_i) lock_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dtx_counters.sv
module dtx_counters #(
  parameter int N = 6,
  parameter int W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        inc_i,
  output logic [N-1:0][W-1:0] cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o[g] <= '0;
      else if (inc_i[g]) cnt_o[g] <= cnt_o[g] + W'(1);
    end
  end
endmodule

// File: rtl/dtx_unit.sv
module dtx_unit
  import dtx_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PG_BITS = 13,
  parameter int PPN_W   = 31,
  parameter int ASN_W   = 8,
  parameter int CNT_W   = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 req_i,
  input  logic [VA_W-1:0]                      va_i,
  input  logic                                 wr_i,
  input  logic                                 alt_i,
  input  logic                                 pte_acc_i,
  input  logic                                 phys_i,
  input  logic                                 priv_pc_i,
  input  logic [1:0]                           cur_mode_i,
  input  logic [1:0]                           alt_mode_i,
  input  logic [ASN_W-1:0]                     asn_i,
  input  logic [5:0]                           opcode_i,
  input  logic [4:0]                           dst_reg_i,
  input  logic [VA_W-1:0]                      ptbr_i,
  input  logic                                 rd_va_i,
  output logic [VA_IMPL-PG_BITS-1:0]           lk_vpn_o,
  output logic [ASN_W-1:0]                     lk_asn_o,
  input  logic                                 lk_hit_i,
  input  logic [PPN_W-1:0]                     lk_ppn_i,
  input  logic [3:0]                           lk_rd_en_i,
  input  logic [3:0]                           lk_wr_en_i,
  input  logic                                 lk_fonr_i,
  input  logic                                 lk_fonw_i,
  output logic                                 vld_o,
  output logic [2:0]                           res_o,
  output logic [PPN_W+PG_BITS-1:0]             pa_o,
  output logic [VA_W-1:0]                      fault_va_o,
  output logic [16:0]                          mm_stat_o,
  output logic [VA_W-1:0]                      va_form_o,
  output logic                                 lock_o,
  output logic [N_CNT-1:0][CNT_W-1:0]          cnt_o
);
  localparam int PA_W = PPN_W + PG_BITS;

  dtx_mode_e         eff_mode;
  dtx_res_e          res_d, res_q;
  logic [PA_W-1:0]   pa_d, pa_q;
  logic [CB_W-1:0]   cause;
  logic              vld_q;
  logic              is_hit, is_miss, is_viol;
  logic [N_CNT-1:0]  inc;

  assign lk_vpn_o = va_i[VA_IMPL-1:PG_BITS];
  assign lk_asn_o = asn_i;

  dtx_mode_sel u_mode (
    .priv_pc_i (priv_pc_i),
    .alt_i     (alt_i),
    .cur_mode_i(dtx_mode_e'(cur_mode_i)),
    .alt_mode_i(dtx_mode_e'(alt_mode_i)),
    .eff_mode_o(eff_mode)
  );

  dtx_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PG_BITS(PG_BITS), .PPN_W(PPN_W)
  ) u_cls (
    .va_i      (va_i),
    .wr_i      (wr_i),
    .pte_acc_i (pte_acc_i),
    .phys_i    (phys_i),
    .cur_mode_i(dtx_mode_e'(cur_mode_i)),
    .eff_mode_i(eff_mode),
    .hit_i     (lk_hit_i),
    .ppn_i     (lk_ppn_i),
    .rd_en_i   (lk_rd_en_i),
    .wr_en_i   (lk_wr_en_i),
    .fonr_i    (lk_fonr_i),
    .fonw_i    (lk_fonw_i),
    .res_o     (res_d),
    .pa_o      (pa_d),
    .cause_o   (cause)
  );

  dtx_fault_regs #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PG_BITS(PG_BITS)
  ) u_fregs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (req_i & res_is_fault(res_d)),
    .rd_va_i   (rd_va_i),
    .va_i      (va_i),
    .cause_i   (cause),
    .opcode_i  (opcode_i),
    .dst_reg_i (dst_reg_i),
    .ptbr_i    (ptbr_i),
    .fault_va_o(fault_va_o),
    .mm_stat_o (mm_stat_o),
    .va_form_o (va_form_o),
    .lock_o    (lock_o)
  );

  assign is_hit  = (res_d == RES_OK) || (res_d == RES_MCHK);
  assign is_miss = (res_d == RES_MISS) || (res_d == RES_PMISS);
  assign is_viol = !is_hit && !is_miss;

  always_comb begin
    inc = '0;
    inc[CI_RD_HIT]  = req_i & ~wr_i & is_hit;
    inc[CI_RD_MISS] = req_i & ~wr_i & is_miss;
    inc[CI_RD_VIOL] = req_i & ~wr_i & is_viol;
    inc[CI_WR_HIT]  = req_i &  wr_i & is_hit;
    inc[CI_WR_MISS] = req_i &  wr_i & is_miss;
    inc[CI_WR_VIOL] = req_i &  wr_i & is_viol;
  end

  dtx_counters #(.N(N_CNT), .W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .cnt_o (cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= RES_OK;
      pa_q  <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) begin
        res_q <= res_d;
        pa_q  <= pa_d;
      end
    end
  end

  assign vld_o = vld_q;
  assign res_o = res_q;
  assign pa_o  = pa_q;
endmodule

// File: rtl/dtx_unit_chk.sv
module dtx_unit_chk #(
  parameter int VA_W  = 64,
  parameter int N_CNT = 6,
  parameter int CNT_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       rd_va_i,
  input logic [VA_W-1:0]            va_i,
  input logic                       vld_o,
  input logic [2:0]                 res_o,
  input logic [VA_W-1:0]            fault_va_o,
  input logic [16:0]                mm_stat_o,
  input logic [VA_W-1:0]            va_form_o,
  input logic                       lock_o,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt_o
);
  a_r13_vld_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);

  a_r13_no_vld_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);

  a_r11_locked_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !rd_va_i) |=> (lock_o && $stable(fault_va_o) && $stable(mm_stat_o)
                              && $stable(va_form_o)));

  a_r11_read_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && rd_va_i) |=> !lock_o);

  a_r11_lock_needs_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (vld_o && res_o >= 3'd1 && res_o <= 3'd4));

  a_r10_captured_address: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> fault_va_o == $past(va_i));

  a_r6_miss_cause_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (mm_stat_o[4] == (res_o == 3'd3 || res_o == 3'd4)));

  a_r3_mchk_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && res_o == 3'd5) |-> !$rose(lock_o));

  a_r12_counters_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> cnt_o == $past(cnt_o));
endmodule

bind dtx_unit dtx_unit_chk #(.VA_W(VA_W), .N_CNT(dtx_pkg::N_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .rd_va_i   (rd_va_i),
  .va_i      (va_i),
  .vld_o     (vld_o),
  .res_o     (res_o),
  .fault_va_o(fault_va_o),
  .mm_stat_o (mm_stat_o),
  .va_form_o (va_form_o),
  .lock_o    (lock_o),
  .cnt_o     (cnt_o)
);

// File: tb/dtx_unit_bench.sv
module dtx_unit_bench;
  localparam int CLK_P = 10;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        req, wr, alt, pte, phys, priv, rd;
  logic [1:0]  cur, altm;
  logic [63:0] va, ptbr;
  logic [7:0]  asn;
  logic [5:0]  opc;
  logic [4:0]  dreg;
  logic        hit, fonr, fonw;
  logic [30:0] ppn;
  logic [3:0]  rde, wre;

  logic [34:0]        lk_vpn;
  logic [7:0]         lk_asn;
  logic               vld;
  logic [2:0]         res;
  logic [43:0]        pa;
  logic [63:0]        fva, vform;
  logic [16:0]        stat;
  logic               lock;
  logic [5:0][CW-1:0] cnt;

  dtx_unit u_dtx_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .va_i(va), .wr_i(wr), .alt_i(alt),
    .pte_acc_i(pte), .phys_i(phys), .priv_pc_i(priv), .cur_mode_i(cur),
    .alt_mode_i(altm), .asn_i(asn), .opcode_i(opc), .dst_reg_i(dreg), .ptbr_i(ptbr),
    .rd_va_i(rd), .lk_vpn_o(lk_vpn), .lk_asn_o(lk_asn), .lk_hit_i(hit),
    .lk_ppn_i(ppn), .lk_rd_en_i(rde), .lk_wr_en_i(wre), .lk_fonr_i(fonr),
    .lk_fonw_i(fonw), .vld_o(vld), .res_o(res), .pa_o(pa), .fault_va_o(fva),
    .mm_stat_o(stat), .va_form_o(vform), .lock_o(lock), .cnt_o(cnt)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic        m_vld = 0, m_lock = 0;
  int          m_res = 0;
  logic [43:0] m_pa = '0;
  logic [63:0] m_fva = '0, m_form = '0;
  logic [16:0] m_stat = '0;
  int          m_cnt[6] = '{default: 0};
  string       m_tag = "R13";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_xlate(output int r, output logic [43:0] p, output logic [5:0] c);
    int m;
    r = 0; p = '0; c = '0;
    m = !priv ? int'(cur) : (alt ? int'(altm) : 0);
    if (phys) begin
      p = va[43:0];
      if (va[63:44] != 0) r = 5;
      return;
    end
    if (!(va[63:47] == '0 || va[63:47] == '1)) begin
      r = 2; c = {1'b1, 3'b000, 1'b1, wr};
      return;
    end
    if (va[47:41] == 7'h7E) begin
      if (cur != 0) begin r = 1; c = {4'b0000, 1'b1, wr}; end
      else p = {{4{va[40]}}, va[39:0]};
      return;
    end
    if (!hit) begin
      r = pte ? 4 : 3; c = {2'b01, 3'b000, wr};
      return;
    end
    p = {ppn, va[12:0]};
    if (wr) begin
      if (!wre[m])   begin r = 2; c = {2'b00, fonw, 1'b0, 2'b11}; end
      else if (fonw) begin r = 2; c = 6'b001001; end
    end else begin
      if (!rde[m])   begin r = 1; c = {3'b000, fonr, 2'b10}; end
      else if (fonr) begin r = 2; c = 6'b000100; end
    end
  endfunction

  task automatic compare();
    chk(vld == m_vld, "R13", "vld", 64'(vld), 64'(m_vld));
    if (m_vld) begin
      chk(res == 3'(m_res), m_tag, "res", 64'(res), 64'(m_res));
      chk(pa == m_pa, m_tag, "pa", 64'(pa), 64'(m_pa));
    end
    chk(lock == m_lock, "R11", "lock", 64'(lock), 64'(m_lock));
    chk(fva == m_fva, "R10", "fault_va", fva, m_fva);
    chk(stat == m_stat, "R10", "mm_stat", 64'(stat), 64'(m_stat));
    chk(vform == m_form, "R10", "va_form", vform, m_form);
    for (int i = 0; i < 6; i++)
      chk(cnt[i] == CW'(m_cnt[i]), "R12", $sformatf("cnt[%0d]", i), 64'(cnt[i]), 64'(m_cnt[i]));
  endtask

  // inputs are set; predict, clock, compare
  task automatic step(input string tag);
    int          r;
    logic [43:0] p;
    logic [5:0]  c;
    logic        cap;
    #1;
    chk(lk_vpn == va[47:13], "R9", "lk_vpn", 64'(lk_vpn), 64'(va[47:13]));
    chk(lk_asn == asn, "R9", "lk_asn", 64'(lk_asn), 64'(asn));
    ref_xlate(r, p, c);
    cap = req && (r >= 1 && r <= 4) && !m_lock;
    m_vld = req;
    if (req) begin
      m_res = r; m_pa = p; m_tag = tag;
      m_cnt[(wr ? 3 : 0) + ((r == 0 || r == 5) ? 0 : (r == 3 || r == 4) ? 1 : 2)] += 1;
    end
    if (cap) begin
      m_fva  = va;
      m_stat = {opc, dreg, c};
      m_form = ptbr | (64'(va[47:13]) << 3);
      m_lock = 1'b1;
    end else if (rd) m_lock = 1'b0;
    @(posedge clk);
    #2;
    compare();
    req = 0; rd = 0;
  endtask

  task automatic defaults();
    req = 0; wr = 0; alt = 0; pte = 0; phys = 0; priv = 0; rd = 0;
    cur = 0; altm = 0; va = 64'h0000_0012_3456_7ABC; ptbr = 64'h0000_0200_0000_0000;
    asn = 8'h5A; opc = 6'h29; dreg = 5'h0B; hit = 1; fonr = 0; fonw = 0;
    ppn = 31'h1234_567; rde = 4'hF; wre = 4'hF;
  endtask

  task automatic go(input string tag);
    req = 1; step(tag);
  endtask

  task automatic release_lock();
    defaults(); rd = 1; step("R11");
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    defaults();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R1 reset state
    compare();

    // R9 read and write hits
    defaults(); go("R9");
    defaults(); wr = 1; cur = 3; wre = 4'b1000; va = 64'hFFFF_8000_0ABC_DEF1; go("R9");

    // R2 effective mode sources
    defaults(); priv = 1; alt = 1; altm = 3; cur = 1; rde = 4'b1000; go("R2");
    defaults(); priv = 1; cur = 3; altm = 2; rde = 4'b0001; go("R2");
    defaults(); cur = 2; altm = 0; rde = 4'b0001; opc = 6'h3F; dreg = 5'h1F; go("R2");

    // R11 fault while locked, then release
    defaults(); wr = 1; va = 64'h0001_0000_0000_0000; go("R11");
    release_lock();
    // R4 bad VA, read pulse in same cycle keeps lock
    defaults(); wr = 1; va = 64'h8000_0000_0000_1000; rd = 1; go("R4");
    defaults(); step("R11");
    release_lock();

    // R5 window
    defaults(); va = 64'hFFFF_FD23_4567_89AB; go("R5");
    defaults(); wr = 1; va = 64'hFFFF_FC12_3456_789A; go("R5");
    defaults(); priv = 1; cur = 3; va = 64'hFFFF_FC00_0000_0040; go("R5");
    release_lock();

    // R6 misses
    defaults(); hit = 0; pte = 1; wr = 1; go("R6");
    release_lock();
    defaults(); hit = 0; go("R6");
    release_lock();

    // R7 write order
    defaults(); wr = 1; cur = 2; wre = 4'b1011; fonw = 1; go("R7");
    release_lock();
    defaults(); wr = 1; cur = 2; wre = 4'b0100; fonw = 1; go("R7");
    release_lock();
    defaults(); wr = 1; cur = 1; wre = 4'b1101; go("R7");
    release_lock();

    // R8 read order
    defaults(); cur = 1; rde = 4'b1101; fonr = 1; go("R8");
    release_lock();
    defaults(); cur = 1; rde = 4'b0010; fonr = 1; go("R8");
    release_lock();
    defaults(); cur = 3; rde = 4'b0111; go("R8");
    release_lock();

    // R3 physical
    defaults(); phys = 1; va = 64'h0000_0ABC_DEF0_1234; go("R3");
    defaults(); phys = 1; wr = 1; va = 64'h0000_1000_0000_0008; go("R3");

    // R13 back-to-back
    for (int i = 0; i < 4; i++) begin
      defaults(); wr = i[0]; va = 64'h0000_0000_0010_0000 + 64'(i) * 64'h2000;
      ppn = 31'(i + 7); go("R13");
    end
    defaults(); step("R13");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule